// File: doc/BRIEF.md
# Isochronous DMA Termination Controller

This block supervises a single DMA transfer between local memory and an isochronous USB endpoint and decides when that transfer is over. Software sets up a byte count, a counter-enable bit and the endpoint direction, then raises the DMA-enable bit. From that rising edge the block asserts a DMA request, counts transfer strobes down from the loaded value and watches for three possible endings: the count running out, an end-of-packet from the USB side, or software dropping the enable.

The counter-based ending applies only to IN endpoints. On OUT endpoints it is never acted on, and setting the counter-enable bit for such a transfer raises a configuration-warning flag instead. When a transfer ends, a one-clock done pulse appears, the request drops in that same cycle, and a 2-bit code records the ending. The code and the warning flag then hold until the next rising edge of DMA-enable.

Top module: `iso_dma_term`

## Requirements
- R1: After reset, dma_req, done, cfg_warn are 0 and end_code is 00.
- R2: In the cycle after a rising edge of dma_en, dma_req is 1 and end_code is 00. The counter is loaded from cnt_init, and cnt_en and dir_in are captured at that edge.
- R3: On an IN transfer (dir_in=1) started with cnt_en=1 and cnt_init=N>0, the transfer ends at the clock edge that samples the N-th xfer_stb. done is 1 in the following cycle with end_code 01. With N=0 the transfer ends at the first edge after the start.
- R4: While a transfer runs with dma_en high, eop=1 ends it at that edge, whatever the count. end_code is 10.
- R5: While a transfer runs, dma_en=0 ends it at that edge with end_code 11. This ending takes priority over eop and over the count running out.
- R6: If eop and the count running out fall in the same cycle, end_code is 10.
- R7: On an OUT transfer (dir_in=0), the count never ends the transfer. cfg_warn is 1 from the start when cnt_en was 1 at the start, and 0 otherwise.
- R8: done lasts exactly one cycle, and dma_req is 0 in every cycle in which done is 1.
- R9: end_code and cfg_warn keep their values until the next rising edge of dma_en. With no new rising edge, strobes and eop cause no further done and no new dma_req.
- R10: On an IN transfer started with cnt_en=0, strobes never end the transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_init | input | CW | Byte count, loaded on a rising edge of dma_en |
| cnt_en | input | 1 | Allows the count running out to end the transfer (sampled at start) |
| dma_en | input | 1 | DMA enable; a rising edge starts a transfer, a low level aborts it |
| dir_in | input | 1 | Endpoint direction at start: 1 = IN, 0 = OUT |
| xfer_stb | input | 1 | One byte moved this cycle |
| eop | input | 1 | End-of-packet seen on the USB side |
| dma_req | output | 1 | DMA request, high while a transfer runs |
| done | output | 1 | One-cycle pulse when a transfer ends |
| end_code | output | 2 | Ending code: 00 none, 01 count, 10 end-of-packet, 11 disabled |
| cfg_warn | output | 1 | Counter enabled on an OUT transfer |

## Verification
The bench builds the block with CW=4. This makes the largest count, 15, reachable in a short run of strobes, so the full-scale count ending is exercised alongside loads of 0 and 1. The narrow width also means an OUT transfer can run well past its loaded count without ending. This shows that the count is ignored there and does not merely wrap.

// File: rtl/iso_dma_pkg.sv
package iso_dma_pkg;

    typedef enum logic [1:0] {
        END_NONE  = 2'b00,
        END_COUNT = 2'b01,
        END_EOP   = 2'b10,
        END_ABORT = 2'b11
    } end_cause_e;

    typedef struct packed {
        logic       en_seen;
        logic       active;
        logic       done;
        logic       cnt_arm;
        logic       warn;
        end_cause_e cause;
    } ctl_t;

endpackage

// File: rtl/iso_dma_cnt.sv
module iso_dma_cnt #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic          at_zero,
    output logic          at_one
);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_d = cnt_q - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign at_zero = (cnt_q == '0);
    assign at_one  = (cnt_q == ONE);
endmodule

// File: rtl/iso_dma_arb.sv
module iso_dma_arb
    import iso_dma_pkg::*;
(
    input  logic       active,
    input  logic       en_lvl,
    input  logic       eop_hit,
    input  logic       zero_hit,
    output logic       end_now,
    output end_cause_e cause
);
    always_comb begin
        end_now = 1'b0;
        cause   = END_NONE;
        if (active) begin
            if (!en_lvl) begin
                end_now = 1'b1;
                cause   = END_ABORT;
            end else if (eop_hit) begin
                end_now = 1'b1;
                cause   = END_EOP;
            end else if (zero_hit) begin
                end_now = 1'b1;
                cause   = END_COUNT;
            end
        end
    end
endmodule

// File: rtl/iso_dma_term.sv
module iso_dma_term
    import iso_dma_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt_init,
    input  logic          cnt_en,
    input  logic          dma_en,
    input  logic          dir_in,
    input  logic          xfer_stb,
    input  logic          eop,
    output logic          dma_req,
    output logic          done,
    output logic [1:0]    end_code,
    output logic          cfg_warn
);
    ctl_t       ctl_d, ctl_q;
    logic       en_rise;
    logic       at_zero, at_one;
    logic       zero_hit;
    logic       end_now;
    end_cause_e arb_cause;

    assign en_rise = dma_en && !ctl_q.en_seen;

    iso_dma_cnt #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (en_rise),
        .load_val (cnt_init),
        .dec      (ctl_q.active && xfer_stb),
        .at_zero  (at_zero),
        .at_one   (at_one)
    );

    assign zero_hit = ctl_q.cnt_arm && (at_zero || (xfer_stb && at_one));

    iso_dma_arb u_arb (
        .active   (ctl_q.active),
        .en_lvl   (dma_en),
        .eop_hit  (eop),
        .zero_hit (zero_hit),
        .end_now  (end_now),
        .cause    (arb_cause)
    );

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.en_seen = dma_en;
        ctl_d.done    = 1'b0;
        if (en_rise) begin
            ctl_d.active  = 1'b1;
            ctl_d.cause   = END_NONE;
            ctl_d.cnt_arm = cnt_en && dir_in;
            ctl_d.warn    = cnt_en && !dir_in;
        end else if (end_now) begin
            ctl_d.active = 1'b0;
            ctl_d.done   = 1'b1;
            ctl_d.cause  = arb_cause;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{en_seen: 1'b0, active: 1'b0, done: 1'b0, cnt_arm: 1'b0,
                       warn: 1'b0, cause: END_NONE};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign dma_req  = ctl_q.active;
    assign done     = ctl_q.done;
    assign end_code = ctl_q.cause;
    assign cfg_warn = ctl_q.warn;
endmodule

// File: rtl/iso_dma_term_chk.sv
module iso_dma_term_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       dma_en,
    input logic       eop,
    input logic       en_seen,
    input logic       dma_req,
    input logic       done,
    input logic [1:0] end_code,
    input logic       cfg_warn
);
    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_en && !en_seen) |=> (dma_req && end_code == 2'b00));

    p_eop_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && dma_en && eop) |=> (done && end_code == 2'b10));

    p_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && !dma_en) |=> (done && end_code == 2'b11));

    p_req_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !dma_req);

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_code_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(dma_en && !en_seen) |=> ($stable(end_code) || done));

    p_warn_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(dma_en && !en_seen) |=> $stable(cfg_warn));
endmodule

bind iso_dma_term iso_dma_term_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dma_en   (dma_en),
    .eop      (eop),
    .en_seen  (ctl_q.en_seen),
    .dma_req  (dma_req),
    .done     (done),
    .end_code (end_code),
    .cfg_warn (cfg_warn)
);

// File: tb/iso_dma_term_tb.sv
module iso_dma_term_tb;
    localparam int CW   = 4;
    localparam int MAXS = 20;

    typedef struct packed {
        logic [7:0] load;
        logic       cen;
        logic       dir;
        logic [7:0] eop_at;
        logic [1:0] exp_code;
        logic [7:0] exp_i;
        logic       exp_warn;
    } vec_t;

    localparam vec_t VEC [0:9] = '{
        '{8'd3,  1'b1, 1'b1, 8'd0, 2'b01, 8'd3,  1'b0},
        '{8'd15, 1'b1, 1'b1, 8'd0, 2'b01, 8'd15, 1'b0},
        '{8'd0,  1'b1, 1'b1, 8'd0, 2'b01, 8'd1,  1'b0},
        '{8'd5,  1'b1, 1'b1, 8'd2, 2'b10, 8'd2,  1'b0},
        '{8'd4,  1'b1, 1'b1, 8'd4, 2'b10, 8'd4,  1'b0},
        '{8'd4,  1'b1, 1'b0, 8'd0, 2'b11, 8'd0,  1'b1},
        '{8'd4,  1'b1, 1'b0, 8'd7, 2'b10, 8'd7,  1'b1},
        '{8'd4,  1'b0, 1'b0, 8'd3, 2'b10, 8'd3,  1'b0},
        '{8'd2,  1'b0, 1'b1, 8'd0, 2'b11, 8'd0,  1'b0},
        '{8'd1,  1'b1, 1'b1, 8'd0, 2'b01, 8'd1,  1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] cnt_init = '0;
    logic          cnt_en = 1'b0, dma_en = 1'b0, dir_in = 1'b0;
    logic          xfer_stb = 1'b0, eop = 1'b0;
    logic          dma_req, done, cfg_warn;
    logic [1:0]    end_code;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    iso_dma_term #(.CW(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_init(cnt_init), .cnt_en(cnt_en),
        .dma_en(dma_en), .dir_in(dir_in), .xfer_stb(xfer_stb), .eop(eop),
        .dma_req(dma_req), .done(done), .end_code(end_code), .cfg_warn(cfg_warn)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic start(input int load, input bit cen, input bit dir);
        @(negedge clk);
        cnt_init = CW'(load);
        cnt_en   = cen;
        dir_in   = dir;
        dma_en   = 1'b1;
        tick();
        chk(dma_req == 1'b1, "R2 req after start", int'(dma_req), 1);
        chk(end_code == 2'b00, "R2 code cleared at start", int'(end_code), 0);
    endtask

    task automatic stop();
        @(negedge clk);
        dma_en = 1'b0;
        tick();
        tick();
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int got_i;
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        chk(dma_req == 1'b0 && done == 1'b0, "R1 req/done after reset", int'({dma_req, done}), 0);
        chk(end_code == 2'b00 && cfg_warn == 1'b0, "R1 code/warn after reset",
            int'({end_code, cfg_warn}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        tick();

        // Vector walk: R3, R4, R6, R7, R10, R5
        for (int v = 0; v < 10; v++) begin
            start(int'(VEC[v].load), VEC[v].cen, VEC[v].dir);
            chk(cfg_warn == VEC[v].exp_warn, "R7 cfg_warn at start", int'(cfg_warn),
                int'(VEC[v].exp_warn));
            got_i = 0;
            for (int i = 1; i <= MAXS; i++) begin
                @(negedge clk);
                xfer_stb = 1'b1;
                eop = (i == int'(VEC[v].eop_at));
                tick();
                if (done) begin
                    got_i = i;
                    break;
                end
            end
            @(negedge clk);
            xfer_stb = 1'b0;
            eop = 1'b0;
            if (got_i == 0) begin
                dma_en = 1'b0;
                tick();
                chk(done == 1'b1, "R5 done on disable", int'(done), 1);
            end else begin
                tick();
                chk(done == 1'b0 && dma_req == 1'b0, "R8 done single cycle",
                    int'({done, dma_req}), 0);
            end
            chk(got_i == int'(VEC[v].exp_i), "R3/R4/R10 ending strobe index", got_i,
                int'(VEC[v].exp_i));
            chk(end_code == VEC[v].exp_code, "R3/R4/R5/R6/R7 end code", int'(end_code),
                int'(VEC[v].exp_code));
            stop();
            chk(end_code == VEC[v].exp_code && cfg_warn == VEC[v].exp_warn,
                "R9 code/warn hold after disable", int'({end_code, cfg_warn}),
                int'({VEC[v].exp_code, VEC[v].exp_warn}));
        end

        // R9: no restart without a new rising edge
        start(10, 1'b1, 1'b1);
        @(negedge clk);
        xfer_stb = 1'b1;
        eop = 1'b1;
        tick();
        chk(done == 1'b1 && dma_req == 1'b0, "R8 done with req low", int'({done, dma_req}), 2);
        for (int k = 0; k < 3; k++) begin
            tick();
            chk(done == 1'b0 && dma_req == 1'b0, "R9 no new done or req", int'({done, dma_req}), 0);
        end
        chk(end_code == 2'b10, "R9 code held", int'(end_code), 2);
        @(negedge clk);
        xfer_stb = 1'b0;
        eop = 1'b0;
        stop();

        // R5: disable wins over eop in the same cycle
        start(6, 1'b1, 1'b1);
        @(negedge clk);
        dma_en = 1'b0;
        eop = 1'b1;
        tick();
        chk(done == 1'b1 && end_code == 2'b11, "R5 disable beats eop",
            int'({done, end_code}), 7);
        @(negedge clk);
        eop = 1'b0;
        tick();

        // R5: disable wins over the count running out
        start(1, 1'b1, 1'b1);
        @(negedge clk);
        dma_en = 1'b0;
        xfer_stb = 1'b1;
        tick();
        chk(end_code == 2'b11, "R5 disable beats count", int'(end_code), 3);
        @(negedge clk);
        xfer_stb = 1'b0;
        tick();

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule